// File: doc/BRIEF.md
# VME Master Address Mapper

This block sits between a local processor's address bus and the VMEbus master logic. Each request carries a 32-bit local address. If the address falls in the upper half of the local map, the block turns it into a VMEbus address, an address-modifier code and a data-width tag, and raises a hit flag. Addresses in the lower half are not VMEbus traffic and produce a miss.

Two settings shape the mapping, and both are held in a small control register. A page bit takes the place of local address bit 31. This lets the 2 GB window reach either half of the 4 GB VMEbus space. The top 64 KB of the window is normally a short-address region: it uses a 16-bit data path, a short-address modifier and forced-high upper address bits. A disable bit folds that region back into ordinary 32-bit space.

The result is registered, so a request presented in one cycle appears on the outputs after the next rising clock edge.

Top module: `vme_master_addr_map`

## Requirements
- R1: After a synchronous active-low reset all outputs are zero, the page bit is 0 and the short-address region is enabled. The first request after reset therefore decodes with those settings.
- R2: A request whose address bit 31 is 0 returns vme_hit=0, vme_addr=0, vme_am=0 and vme_wid=00.
- R3: With page bit 0, a window address outside the short region maps to {1'b0, addr[30:0]} with vme_am=09h, vme_wid=10 (32-bit data) and vme_hit=1.
- R4: With page bit 1, a window address outside the short region maps to {1'b1, addr[30:0]}, again with vme_am=09h and vme_wid=10.
- R5: When the short region is enabled, addresses FFFF0000h to FFFFFFFFh map to {16'hFFFF, addr[15:0]} with vme_am=29h and vme_wid=01 (16-bit data). The page bit has no effect on these addresses.
- R6: When the short-region disable bit is 1, the top 64 KB decodes like any other window address: page substitution on bit 31, vme_am=09h and vme_wid=10.
- R7: The result of a request appears one cycle later with out_valid=1. In a cycle after which no request was presented, out_valid is 0 and all result outputs are 0.
- R8: ctl_we=1 at a rising edge loads ctl_page and ctl_short_dis into the control register. A request presented in that same cycle still decodes with the previous settings; later requests use the new ones.
- R9: The region edges decode exactly. 80000000h with page 0 maps to 00000000h. FFFEFFFFh is an ordinary 32-bit address. FFFF0000h is the first short-region address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Load the control register this edge |
| ctl_page | input | 1 | New page bit (VME address bit 31 for the window) |
| ctl_short_dis | input | 1 | New short-region disable bit |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Local processor address |
| out_valid | output | 1 | Result valid (one cycle after request) |
| vme_addr | output | 32 | Mapped VMEbus address |
| vme_am | output | 6 | Address modifier code |
| vme_wid | output | 2 | Data width tag: 00 none, 01 16-bit, 10 32-bit |
| vme_hit | output | 1 | Address lies in the VMEbus window |

## Verification
The hardest case to reach is a control-register write that lands in the same cycle as a request, together with its effect on the request that follows. The old settings must apply to the first request and the new settings to the second.

The stimulus drives ctl_we together with req_valid in one cycle and sends a second request at the same address straight after it. The scoreboard records the expected result for the colliding request before it updates its own copy of the settings.

A second hard case is the page-1, disable-on corner, where FFFF1234h must come out unchanged but as a 32-bit access. The stimulus also probes the edges on each side of FFFF0000h.

// File: rtl/vmap_pkg.sv
// Package: shared widths, codes and the decoded-result type for the
// VME master address mapper. Assumes a 32-bit local and VME address space.
package vmap_pkg;
    localparam int VM_AW       = 32;   // address width
    localparam int VM_SHORT_W  = 16;   // width of the short-region offset
    localparam int VM_AM_W     = 6;    // address modifier width

    localparam logic [VM_AM_W-1:0] AM_LONG_DATA = 6'h09;
    localparam logic [VM_AM_W-1:0] AM_SHORT     = 6'h29;

    typedef enum logic [1:0] {
        WID_NONE = 2'b00,
        WID_D16  = 2'b01,
        WID_D32  = 2'b10
    } wid_e;

    typedef struct packed {
        logic               hit;
        logic [VM_AW-1:0]   addr;
        logic [VM_AM_W-1:0] am;
        wid_e               wid;
    } vmap_res_t;
endpackage

// File: rtl/vmap_ctl_reg.sv
// Control register for the mapper: page bit and short-region disable bit.
// Assumes a synchronous active-low reset that clears both bits.
module vmap_ctl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic page_d,
    input  logic sdis_d,
    output logic page_q,
    output logic sdis_q
);
    // Hold the two settings; load both on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= 1'b0;
            sdis_q <= 1'b0;
        end else if (we) begin
            page_q <= page_d;
            sdis_q <= sdis_d;
        end
    end

    // R1: first cycle out of reset sees cleared settings
    p_ctl_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!page_q && !sdis_q));

    // R8: bits change only after a write strobe
    p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> ($stable(page_q) && $stable(sdis_q)));
endmodule

// File: rtl/vmap_decode.sv
// Combinational decode of one local address into VME address, modifier,
// width and hit. Assumes the window is the upper half of the local map and
// the short region is the topmost 2**SHORT_W bytes.
module vmap_decode
    import vmap_pkg::*;
#(
    parameter int AW      = VM_AW,
    parameter int SHORT_W = VM_SHORT_W
) (
    input  logic [AW-1:0] addr,
    input  logic          page,
    input  logic          sdis,
    output vmap_res_t     res
);
    localparam int TOP_W = AW - SHORT_W;

    logic in_win;
    logic top_ones;
    logic in_short;

    // Classify the address against window and short region.
    always_comb begin
        in_win   = addr[AW-1];
        top_ones = &addr[AW-1:SHORT_W];
        in_short = in_win && top_ones && !sdis;
    end

    // Build the mapped result for the selected region.
    always_comb begin
        res = '0;
        if (in_short) begin
            res.hit  = 1'b1;
            res.addr = {{TOP_W{1'b1}}, addr[SHORT_W-1:0]};
            res.am   = AM_SHORT;
            res.wid  = WID_D16;
        end else if (in_win) begin
            res.hit  = 1'b1;
            res.addr = {page, addr[AW-2:0]};
            res.am   = AM_LONG_DATA;
            res.wid  = WID_D32;
        end
    end
endmodule

// File: rtl/vmap_out_stage.sv
// Output register for the mapper: captures one decoded result per request
// and clears everything in cycles without a request.
module vmap_out_stage
    import vmap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  vmap_res_t in_res,
    output logic      out_valid,
    output vmap_res_t out_res
);
    // Register the result, or zeros when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= 1'b1;
            out_res   <= in_res;
        end
    end

    // R7: idle output carries no stale data
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_res == '0));
endmodule

// File: rtl/vme_master_addr_map.sv
// Top: local-to-VME master address mapper. One registered stage; the
// control register feeds the decode, whose result is registered once.
module vme_master_addr_map
    import vmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        ctl_page,
    input  logic        ctl_short_dis,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        out_valid,
    output logic [31:0] vme_addr,
    output logic [5:0]  vme_am,
    output logic [1:0]  vme_wid,
    output logic        vme_hit
);
    logic      page_q;
    logic      sdis_q;
    vmap_res_t dec_res;
    vmap_res_t reg_res;

    vmap_ctl_reg u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctl_we),
        .page_d (ctl_page),
        .sdis_d (ctl_short_dis),
        .page_q (page_q),
        .sdis_q (sdis_q)
    );

    vmap_decode #(.AW(VM_AW), .SHORT_W(VM_SHORT_W)) u_dec (
        .addr (req_addr),
        .page (page_q),
        .sdis (sdis_q),
        .res  (dec_res)
    );

    vmap_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_res    (dec_res),
        .out_valid (out_valid),
        .out_res   (reg_res)
    );

    // Unpack the registered result onto the ports.
    always_comb begin
        vme_hit  = reg_res.hit;
        vme_addr = reg_res.addr;
        vme_am   = reg_res.am;
        vme_wid  = reg_res.wid;
    end

    // R7: one-cycle latency
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2: lower half never hits
    p_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[31]) |=> (out_valid && !vme_hit && vme_am == 6'h00));

    // R3: low offset always passes through for window addresses
    p_low_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31]) |=> (vme_hit && vme_addr[15:0] == $past(req_addr[15:0])));

    // R4: outside the top 64 KB, bit 31 comes from the page bit
    p_page_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31] && !(&req_addr[31:16])) |=> (vme_addr[31] == $past(page_q)));

    // R5: short modifier implies forced-high upper bits and 16-bit width
    p_short_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vme_am == AM_SHORT) |-> (vme_addr[31:16] == 16'hFFFF && vme_wid == WID_D16));

    // R6: with the region disabled no short modifier is issued
    p_no_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sdis_q) |=> (vme_am != AM_SHORT));
endmodule

// File: tb/tb_vme_master_addr_map.sv
module tb_vme_master_addr_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic        ctl_page = 1'b0;
    logic        ctl_short_dis = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid;
    logic [31:0] vme_addr;
    logic [5:0]  vme_am;
    logic [1:0]  vme_wid;
    logic        vme_hit;

    typedef struct packed {
        logic        hit;
        logic [31:0] a;
        logic [5:0]  am;
        logic [1:0]  w;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    checks = 0;
    int    failures = 0;
    logic  m_page = 1'b0;
    logic  m_sdis = 1'b0;
    logic  req_seen = 1'b0;
    logic  done = 1'b0;
    logic  mon_on = 1'b0;

    always #2.5 clk = ~clk;

    vme_master_addr_map dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_page(ctl_page),
        .ctl_short_dis(ctl_short_dis), .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .vme_addr(vme_addr), .vme_am(vme_am),
        .vme_wid(vme_wid), .vme_hit(vme_hit)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [31:0] a, input logic pg, input logic sd);
        exp_t e;
        e = '0;
        if (a[31] && a[31:16] == 16'hFFFF && !sd) begin
            e.hit = 1'b1; e.a = {16'hFFFF, a[15:0]}; e.am = 6'h29; e.w = 2'b01;
        end else if (a[31]) begin
            e.hit = 1'b1; e.a = {pg, a[30:0]}; e.am = 6'h09; e.w = 2'b10;
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] a, input string tag);
        @(negedge clk);
        ctl_we = 1'b0;
        req_valid = 1'b1;
        req_addr = a;
        expq.push_back(model(a, m_page, m_sdis));
        tagq.push_back(tag);
    endtask

    // Request and control write in the same cycle (old settings apply).
    task automatic send_with_ctl(input logic [31:0] a, input logic pg, input logic sd, input string tag);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_page = pg;
        ctl_short_dis = sd;
        req_valid = 1'b1;
        req_addr = a;
        expq.push_back(model(a, m_page, m_sdis));
        tagq.push_back(tag);
        m_page = pg;
        m_sdis = sd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ctl_we = 1'b0;
            req_valid = 1'b0;
            req_addr = 32'h5A5A_5A5A;
        end
    endtask

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    always @(posedge clk) req_seen <= req_valid && rst_n;

    // Monitor: compare outputs against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (mon_on) begin
            check(out_valid == req_seen, "R7",
                  $sformatf("out_valid actual=%0b expected=%0b", out_valid, req_seen));
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R7", "result actual=present expected=none");
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check({vme_hit, vme_addr, vme_am, vme_wid} == e, t,
                          $sformatf("actual=%0b/%h/%h/%b expected=%0b/%h/%h/%b",
                                    vme_hit, vme_addr, vme_am, vme_wid, e.hit, e.a, e.am, e.w));
                end
            end else begin
                check({vme_hit, vme_addr, vme_am, vme_wid} == '0, "R7",
                      $sformatf("idle outputs actual=%h expected=0", {vme_hit, vme_addr, vme_am, vme_wid}));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs even with a request pending
        req_valid = 1'b1;
        req_addr = 32'h8000_0001;
        repeat (3) @(negedge clk);
        check({out_valid, vme_hit, vme_addr, vme_am, vme_wid} == '0, "R1",
              $sformatf("reset outputs actual=%h expected=0", {out_valid, vme_hit, vme_addr, vme_am, vme_wid}));
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1 / R3: defaults are page 0 and short region on
        send(32'h8000_1234, "R1");
        send(32'hFFFF_0010, "R1");
        // R2: lower half misses
        send(32'h1234_5678, "R2");
        send(32'h7FFF_FFFF, "R2");
        idle(2);
        // R9: region edges
        send(32'h8000_0000, "R9");
        send(32'hFFFE_FFFF, "R9");
        send(32'hFFFF_0000, "R9");
        // R3: general window addresses, page 0
        send(32'hC0DE_BEEF, "R3");
        idle(1);
        // R8: write in the same cycle as a request, then the follow-up
        send_with_ctl(32'h9ABC_DEF0, 1'b1, 1'b0, "R8");
        send(32'h9ABC_DEF0, "R8");
        // R4: page 1
        send(32'hA000_0004, "R4");
        send(32'hFFFE_0000, "R4");
        // R5: short region ignores page
        send(32'hFFFF_8000, "R5");
        send(32'hFFFF_FFFF, "R5");
        idle(1);
        // R6: short region disabled, page 0 then page 1
        send_with_ctl(32'hFFFF_1234, 1'b0, 1'b1, "R5");
        send(32'hFFFF_1234, "R6");
        send_with_ctl(32'hFFFF_1234, 1'b1, 1'b1, "R6");
        send(32'hFFFF_1234, "R6");
        send(32'h0000_FFFF, "R2");
        // Back to enabled, mixed burst
        send_with_ctl(32'hFFFF_4321, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 16; i++) begin
            send(32'h8765_4321 ^ (i * 32'h1F00_0F11), "R3");
        end
        idle(4);
        check(expq.size() == 0, "R7",
              $sformatf("pending results actual=%0d expected=0", expq.size()));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule